// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block turns a processor-side bus address into a routing decision. Eight windows are held in a small register file. Each window has a control word, a base and, for the lower-numbered windows, a pair of remap registers. The control word holds an enable, a destination identifier, an attribute byte and a size mask. A lookup compares the upper address bits against every enabled window in parallel. The lowest-numbered window that matches supplies the destination, the attribute and a translated address. An address that no enabled window covers raises a miss.

Window size is a right-aligned run of ones in a 16-bit field, counted in 64 KB pages. Mask bits that are one let the corresponding address bits vary inside the window. On a window with remap registers, the address bits above the window size are taken from the remap-low value, and the remap-high register supplies the bits beyond 32. If remap-low equals the base, the translation is the identity. Windows without remap registers return the address unchanged, with zero high bits.

Configuration uses a plain write/read port. A lookup is presented with a valid strobe, and its registered result appears on the next clock edge.

Top module: `addr_window_decoder`

## Requirements
- R1: Configuration addressing and readback. `cfg_addr[4:2]` selects the window and `cfg_addr[1:0]` selects the register: 0 control, 1 base, 2 remap-low, 3 remap-high. A write with `cfg_we` high takes effect at the clock edge. `cfg_rdata` shows the addressed register combinationally. Bits 15:0 of base and of remap-low always read 0.
- R2: The control word layout is: bit 31 enable, bits 27:24 destination, bits 23:16 attribute, bits 15:0 size mask. Bits 30:28 read 0 whatever was written.
- R3: A size mask of (2^k)-1 gives a window of 2^k pages of 64 KB, so 0x0000 gives 64 KB and 0x00FF gives 16 MB. An address hits when its bits 31:16 equal the base in every position where the mask bit is 0. Addresses one page past the window end miss.
- R4: After reset every register is 0, so all windows are disabled. A window whose enable bit is 0 never hits.
- R5: When several enabled windows hit, the result reports the lowest-numbered one on `res_win`, together with its destination, attribute and translation.
- R6: On a hit in windows 0 to 3, the result is formed as follows. `res_addr[31:16]` takes the remap-low bits where the mask is 0 and the address bits where the mask is 1. `res_addr[15:0]` equals the input address bits. `res_addr_hi` equals that window's remap-high register.
- R7: Windows 4 to 7 have no remap registers. On a hit in one of them, `res_addr` equals the input address and `res_addr_hi` is 0. Their remap registers read 0, and writes to them are ignored.
- R8: A lookup presented with `lk_valid` in one cycle produces `res_valid` high in the next cycle. A cycle without `lk_valid` produces `res_valid` low in the next cycle.
- R9: While `res_valid` is high, exactly one of `res_hit` and `res_miss` is high. While `res_valid` is low, both are low. On a miss, `res_addr` equals the input address, and `res_win`, `res_target`, `res_attr` and `res_addr_hi` are 0.
- R10: A window with remap registers whose remap-low equals its base, and whose remap-high is 0, returns the input address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Window index (4:2) and register select (1:0) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Addressed register contents |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Some enabled window covers the address |
| res_miss | output | 1 | No enabled window covers the address |
| res_win | output | 3 | Index of the winning window |
| res_target | output | 4 | Destination of the winning window |
| res_attr | output | 8 | Attribute of the winning window |
| res_addr | output | 32 | Translated address, bits 31:0 |
| res_addr_hi | output | 32 | Translated address bits beyond 32 |

## Verification
The bound checker holds several properties on every cycle. It checks the one-cycle result latency and the exclusive hit/miss flags. It also checks that the low 16 address bits always pass through, and that misses and hits in the windows without remap registers return the input address with zero high bits. Other behaviours depend on the programmed register contents, and only the bench's scenarios can show them. These are the page-granular window boundaries, lowest-index priority between overlapping windows, remap substitution under the size mask, ignored writes to absent remap registers, and the reset state of the register file.

// File: rtl/awd_pkg.sv
package awd_pkg;

   localparam int CFG_DW      = 32;
   localparam int CTRL_EN_BIT = 31;
   localparam int CTRL_TGT_LO = 24;
   localparam int CTRL_TGT_W  = 4;
   localparam int CTRL_ATR_LO = 16;
   localparam int CTRL_ATR_W  = 8;
   localparam int CTRL_SZ_LO  = 0;
   localparam int CTRL_SZ_W   = 16;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BASE = 2'd1,
      SEL_RLO  = 2'd2,
      SEL_RHI  = 2'd3
   } awd_sel_e;

   typedef struct packed {
      logic                  en;
      logic [CTRL_TGT_W-1:0] tgt;
      logic [CTRL_ATR_W-1:0] attr;
   } awd_ctrl_t;

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 4,
   parameter int UP_W      = 16,
   parameter int PAGE_W    = 16,
   parameter int HI_W      = 32,
   localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [WIN_IDX_W-1:0]           win_sel,
   input  awd_sel_e                       reg_sel,
   input  logic [CFG_DW-1:0]              wdata,
   output logic [CFG_DW-1:0]              rdata,
   output awd_ctrl_t [NUM_WIN-1:0]        ctrl_o,
   output logic [NUM_WIN-1:0][UP_W-1:0]   size_o,
   output logic [NUM_WIN-1:0][UP_W-1:0]   base_o,
   output logic [NUM_WIN-1:0][UP_W-1:0]   rlo_o,
   output logic [NUM_WIN-1:0][HI_W-1:0]   rhi_o
);

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      logic hit_w;
      assign hit_w = we && (win_sel == WIN_IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_o[g] <= '0;
            size_o[g] <= '0;
            base_o[g] <= '0;
         end else if (hit_w) begin
            if (reg_sel == SEL_CTRL) begin
               ctrl_o[g].en   <= wdata[CTRL_EN_BIT];
               ctrl_o[g].tgt  <= wdata[CTRL_TGT_LO +: CTRL_TGT_W];
               ctrl_o[g].attr <= wdata[CTRL_ATR_LO +: CTRL_ATR_W];
               size_o[g]      <= wdata[CTRL_SZ_LO +: UP_W];
            end
            if (reg_sel == SEL_BASE) begin
               base_o[g] <= wdata[PAGE_W +: UP_W];
            end
         end
      end

      if (g < NUM_REMAP) begin : g_remap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rlo_o[g] <= '0;
               rhi_o[g] <= '0;
            end else if (hit_w) begin
               if (reg_sel == SEL_RLO) rlo_o[g] <= wdata[PAGE_W +: UP_W];
               if (reg_sel == SEL_RHI) rhi_o[g] <= wdata[HI_W-1:0];
            end
         end
      end else begin : g_noremap
         assign rlo_o[g] = '0;
         assign rhi_o[g] = '0;
      end
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (win_sel == WIN_IDX_W'(w)) begin
            case (reg_sel)
               SEL_CTRL: begin
                  rdata[CTRL_EN_BIT]                = ctrl_o[w].en;
                  rdata[CTRL_TGT_LO +: CTRL_TGT_W]  = ctrl_o[w].tgt;
                  rdata[CTRL_ATR_LO +: CTRL_ATR_W]  = ctrl_o[w].attr;
                  rdata[CTRL_SZ_LO +: UP_W]         = size_o[w];
               end
               SEL_BASE: rdata[PAGE_W +: UP_W] = base_o[w];
               SEL_RLO:  rdata[PAGE_W +: UP_W] = rlo_o[w];
               default:  rdata[HI_W-1:0]       = rhi_o[w];
            endcase
         end
      end
   end

endmodule

// File: rtl/awd_match.sv
module awd_match #(
   parameter int NUM_WIN = 8,
   parameter int UP_W    = 16
)(
   input  logic [UP_W-1:0]              addr_up,
   input  logic [NUM_WIN-1:0]           en,
   input  logic [NUM_WIN-1:0][UP_W-1:0] size,
   input  logic [NUM_WIN-1:0][UP_W-1:0] base,
   output logic [NUM_WIN-1:0]           hit_vec
);

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
      logic [UP_W-1:0] diff;
      assign diff       = (addr_up ^ base[g]) & ~size[g];
      assign hit_vec[g] = en[g] && (diff == '0);
   end

endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
   parameter int NUM_WIN = 8,
   localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
   input  logic [NUM_WIN-1:0]   req,
   output logic                 any,
   output logic [WIN_IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (req[w]) idx = WIN_IDX_W'(w);
      end
   end

   assign any = |req;

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 4,
   parameter int ADDR_W    = 32,
   parameter int PAGE_W    = 16,
   parameter int HI_W      = 32,
   localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int CFG_AW    = WIN_IDX_W + 2,
   localparam int UP_W      = ADDR_W - PAGE_W
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   input  logic                  lk_valid,
   input  logic [ADDR_W-1:0]     lk_addr,
   output logic                  res_valid,
   output logic                  res_hit,
   output logic                  res_miss,
   output logic [WIN_IDX_W-1:0]  res_win,
   output logic [3:0]            res_target,
   output logic [7:0]            res_attr,
   output logic [ADDR_W-1:0]     res_addr,
   output logic [HI_W-1:0]       res_addr_hi
);

   if (NUM_REMAP > NUM_WIN || NUM_REMAP < 0) begin : g_chk_remap
      $error("NUM_REMAP must lie between 0 and NUM_WIN");
   end
   if (UP_W < 1 || UP_W > CTRL_SZ_W || ADDR_W > CFG_DW) begin : g_chk_addr
      $error("ADDR_W must exceed PAGE_W by 1 to 16 bits and fit the data word");
   end
   if (HI_W < 1 || HI_W > CFG_DW) begin : g_chk_hi
      $error("HI_W must lie between 1 and the data word width");
   end

   awd_ctrl_t [NUM_WIN-1:0]      ctrl;
   logic [NUM_WIN-1:0][UP_W-1:0] size, base, rlo;
   logic [NUM_WIN-1:0][HI_W-1:0] rhi;
   logic [NUM_WIN-1:0]           en_vec, hit_vec, remap_cap;
   logic                         any_hit;
   logic [WIN_IDX_W-1:0]         win_idx;

   awd_regfile #(
      .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP),
      .UP_W(UP_W), .PAGE_W(PAGE_W), .HI_W(HI_W)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .win_sel (cfg_addr[CFG_AW-1:2]),
      .reg_sel (awd_sel_e'(cfg_addr[1:0])),
      .wdata   (cfg_wdata),
      .rdata   (cfg_rdata),
      .ctrl_o  (ctrl),
      .size_o  (size),
      .base_o  (base),
      .rlo_o   (rlo),
      .rhi_o   (rhi)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_vec
      assign en_vec[g]    = ctrl[g].en;
      assign remap_cap[g] = (g < NUM_REMAP);
   end

   awd_match #(.NUM_WIN(NUM_WIN), .UP_W(UP_W)) match_i (
      .addr_up (lk_addr[ADDR_W-1:PAGE_W]),
      .en      (en_vec),
      .size    (size),
      .base    (base),
      .hit_vec (hit_vec)
   );

   awd_prio #(.NUM_WIN(NUM_WIN)) prio_i (
      .req (hit_vec),
      .any (any_hit),
      .idx (win_idx)
   );

   logic [UP_W-1:0]   sel_size, sel_rlo, xl_up;
   logic [HI_W-1:0]   nxt_hi;
   logic [ADDR_W-1:0] nxt_addr;
   logic [3:0]        nxt_tgt;
   logic [7:0]        nxt_attr;

   always_comb begin
      sel_size = size[win_idx];
      sel_rlo  = rlo[win_idx];
      xl_up    = (sel_rlo & ~sel_size) | (lk_addr[ADDR_W-1:PAGE_W] & sel_size);
      nxt_addr = lk_addr;
      nxt_hi   = '0;
      nxt_tgt  = '0;
      nxt_attr = '0;
      if (any_hit) begin
         nxt_tgt  = ctrl[win_idx].tgt;
         nxt_attr = ctrl[win_idx].attr;
         if (remap_cap[win_idx]) begin
            nxt_addr = {xl_up, lk_addr[PAGE_W-1:0]};
            nxt_hi   = rhi[win_idx];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_hit     <= 1'b0;
         res_miss    <= 1'b0;
         res_win     <= '0;
         res_target  <= '0;
         res_attr    <= '0;
         res_addr    <= '0;
         res_addr_hi <= '0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= lk_valid && any_hit;
         res_miss  <= lk_valid && !any_hit;
         if (lk_valid) begin
            res_win     <= any_hit ? win_idx : '0;
            res_target  <= nxt_tgt;
            res_attr    <= nxt_attr;
            res_addr    <= nxt_addr;
            res_addr_hi <= nxt_hi;
         end
      end
   end

endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 4,
   parameter int ADDR_W    = 32,
   parameter int PAGE_W    = 16,
   parameter int HI_W      = 32,
   localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 lk_valid,
   input logic [ADDR_W-1:0]    lk_addr,
   input logic                 res_valid,
   input logic                 res_hit,
   input logic                 res_miss,
   input logic [WIN_IDX_W-1:0] res_win,
   input logic [ADDR_W-1:0]    res_addr,
   input logic [HI_W-1:0]      res_addr_hi
);

   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);

   assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_hit != res_miss));

   assert_flags_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_hit && !res_miss));

   assert_low_bits_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_addr[PAGE_W-1:0] == $past(lk_addr[PAGE_W-1:0]));

   assert_miss_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (res_miss |-> (res_addr == $past(lk_addr) && res_addr_hi == '0)));

   assert_plain_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> ((res_hit && int'(res_win) >= NUM_REMAP)
                    |-> (res_addr == $past(lk_addr) && res_addr_hi == '0)));

endmodule

bind addr_window_decoder awd_checker #(
   .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W),
   .PAGE_W(PAGE_W), .HI_W(HI_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
   .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
   .res_win(res_win), .res_addr(res_addr), .res_addr_hi(res_addr_hi)
);

// File: tb/addr_window_decoder_tb_top.sv
module addr_window_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        res_valid, res_hit, res_miss;
   logic [2:0]  res_win;
   logic [3:0]  res_target;
   logic [7:0]  res_attr;
   logic [31:0] res_addr, res_addr_hi;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] m_ctrl [8];
   logic [31:0] m_base [8];
   logic [31:0] m_rlo  [8];
   logic [31:0] m_rhi  [8];

   always #5 clk = ~clk;

   addr_window_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
      .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
      .res_miss(res_miss), .res_win(res_win), .res_target(res_target),
      .res_attr(res_attr), .res_addr(res_addr), .res_addr_hi(res_addr_hi)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int w, input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {3'(w), 2'(sel)}; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         0: m_ctrl[w] = d & 32'h8FFF_FFFF;
         1: m_base[w] = d & 32'hFFFF_0000;
         2: if (w < 4) m_rlo[w] = d & 32'hFFFF_0000;
         default: if (w < 4) m_rhi[w] = d;
      endcase
   endtask

   task automatic rd(input int w, input int sel, input string req);
      logic [31:0] e;
      cfg_addr = {3'(w), 2'(sel)};
      #1;
      case (sel)
         0: e = m_ctrl[w];
         1: e = m_base[w];
         2: e = m_rlo[w];
         default: e = m_rhi[w];
      endcase
      check(req, 64'(cfg_rdata), 64'(e));
   endtask

   function automatic void model(input logic [31:0] a, output logic hit, output logic [2:0] win,
                                 output logic [3:0] t, output logic [7:0] at,
                                 output logic [31:0] ea, output logic [31:0] eh);
      hit = 1'b0; win = '0; t = '0; at = '0; ea = a; eh = '0;
      for (int w = 7; w >= 0; w--) begin
         logic [15:0] sz;
         sz = m_ctrl[w][15:0];
         if (m_ctrl[w][31] && (((a[31:16] ^ m_base[w][31:16]) & ~sz) == 16'h0)) begin
            hit = 1'b1; win = 3'(w);
            t = m_ctrl[w][27:24]; at = m_ctrl[w][23:16];
            if (w < 4) begin
               ea = {(m_rlo[w][31:16] & ~sz) | (a[31:16] & sz), a[15:0]};
               eh = m_rhi[w];
            end else begin
               ea = a; eh = '0;
            end
         end
      end
   endfunction

   task automatic lookup(input logic [31:0] a, input string req);
      logic h; logic [2:0] wi; logic [3:0] t; logic [7:0] at; logic [31:0] ea, eh;
      model(a, h, wi, t, at, ea, eh);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_valid = 1'b0;
      check({req, " R8 valid"}, 64'(res_valid), 64'd1);
      check({req, " flags"}, 64'({res_hit, res_miss}), 64'({h, !h}));
      check({req, " win/tgt/attr"}, 64'({res_win, res_target, res_attr}), 64'({wi, t, at}));
      check({req, " addr"}, {res_addr_hi, res_addr}, {eh, ea});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int w = 0; w < 8; w++) begin
         m_ctrl[w] = '0; m_base[w] = '0; m_rlo[w] = '0; m_rhi[w] = '0;
      end
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 reset state
      check("R4 reset res_valid", 64'(res_valid), 64'd0);
      for (int w = 0; w < 8; w++)
         for (int s = 0; s < 4; s++) rd(w, s, "R4 reset register");
      lookup(32'h0000_0000, "R4 R9 all disabled miss");
      lookup(32'hDEAD_BEEF, "R9 miss passthrough");

      // R8 idle cycle gives no result
      @(negedge clk);
      check("R8 idle", 64'({res_valid, res_hit, res_miss}), 64'd0);

      // R1 R2 programming and readback
      wr(0, 0, 32'hF3E8_00FF);
      rd(0, 0, "R2 pad bits read 0");
      wr(0, 1, 32'h9000_1234);
      rd(0, 1, "R1 base low bits read 0");
      wr(0, 2, 32'h4000_ABCD);
      wr(0, 3, 32'h0000_0001);
      rd(0, 2, "R1 remap low readback");
      rd(0, 3, "R1 remap high readback");
      lookup(32'h90AB_CDEF, "R6 remap hit");
      lookup(32'h90FF_FFFF, "R3 last byte of 16MB window");
      lookup(32'h9100_0000, "R3 one page past end");

      // R3 R7 size zero window without remap
      wr(5, 0, 32'h8712_0000);
      wr(5, 1, 32'hF000_0000);
      lookup(32'hF000_FFFF, "R3 R7 64KB window hit");
      lookup(32'hF001_0000, "R3 64KB window next page");
      wr(5, 2, 32'h1234_0000);
      wr(5, 3, 32'h5555_5555);
      rd(5, 2, "R7 absent remap low");
      rd(5, 3, "R7 absent remap high");
      lookup(32'hF000_0042, "R7 passthrough after ignored write");

      // R4 disabled window
      wr(6, 0, 32'h0900_FFFF);
      wr(6, 1, 32'hA000_0000);
      lookup(32'hA000_0000, "R4 disabled window miss");

      // R5 overlap priority
      wr(2, 0, 32'h8500_0FFF);
      wr(2, 1, 32'h2000_0000);
      wr(1, 0, 32'h8600_00FF);
      wr(1, 1, 32'h2000_0000);
      wr(1, 2, 32'h7000_0000);
      lookup(32'h2000_1234, "R5 lowest index wins");
      lookup(32'h2100_0000, "R5 only upper window");

      // R10 identity remap
      wr(3, 0, 32'h8A00_0FFF);
      wr(3, 1, 32'hC000_0000);
      wr(3, 2, 32'hC000_0000);
      lookup(32'hC0F1_2345, "R10 identity translation");

      // randomized programs
      for (int round = 0; round < 12; round++) begin
         for (int w = 0; w < 8; w++) begin
            logic [31:0] c;
            int k;
            k = int'($urandom % 17);
            c = $urandom;
            c[31] = ($urandom % 4) != 0;
            c[15:0] = 16'((32'd1 << k) - 1);
            wr(w, 0, c);
            wr(w, 1, $urandom);
            wr(w, 2, $urandom);
            wr(w, 3, $urandom);
         end
         for (int w = 0; w < 8; w++) rd(w, 0, "R1 R2 random readback");
         for (int n = 0; n < 40; n++) begin
            logic [31:0] a, r;
            int w;
            r = $urandom;
            if ($urandom % 3 != 0) begin
               w = int'($urandom % 8);
               a = {m_base[w][31:16] ^ (r[31:16] & m_ctrl[w][15:0]), r[15:0]};
            end else begin
               a = r;
            end
            lookup(a, "R3 R5 R6 R7 R9 random");
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule